// File: doc/BRIEF.md
# Bit-Plane Byte Transposer with Character-Class Streams

This block takes one block of 128 input bytes per transfer and turns it into eight bit planes: plane i collects bit i of every byte, with plane position j belonging to byte j. From those planes it forms four character-class streams. Each class stream carries one bit per byte position, set when that byte belongs to the class. Each class is fixed at elaboration by a 256-entry membership vector.

Membership is not found by comparing bytes one at a time. Each class is a binary decision tree whose selects are whole bit planes, so every position of the block is classified at once by wide AND/OR/NOT logic. The planes and the class streams leave through one register stage. That stage has a valid/ready handshake on both sides, and the output alignment always matches the input byte order.

The default classes are a digit range, a two-character literal set, a negated digit range, and an any-character class that excludes newline. A matcher further down the chain uses the planes and the class streams as its per-position inputs.

Top module: `bitplane_classifier`

## Requirements
- R1: Byte j of a block sits at `in_data[8j+7:8j]`. Plane i is presented at `out_planes[128i+127:128i]`, and its bit j equals bit i of byte j.
- R2: Class k is presented at `out_class[128k+127:128k]`, and its bit j is 1 exactly when byte j is a member of class k.
- R3: By default, class 0 is the range 0x30..0x39 (ASCII digits).
- R4: By default, class 1 is the literal set {0x7A, 0x39} ('z' and '9').
- R5: By default, class 2 is the negation of the digit range: every code except 0x30..0x39, including 0x00 and 0xFF.
- R6: By default, class 3 is the line-mode any-character class: every code except 0x0A (newline).
- R7: A block is accepted on a rising edge where `in_valid` and `in_ready` are both 1. After that edge `out_valid` is 1 and the results for that block are on the outputs.
- R8: `in_ready` is 1 when `out_valid` is 0 or `out_ready` is 1. While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_planes` and `out_class` hold their values and no new block is taken.
- R9: When `rst_n` is low, `out_valid` is 0 at once, without waiting for a clock edge, and `in_ready` is 1.
- R10: When `out_ready` stays 1, one block is accepted on every cycle with no idle cycle between blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Block can be taken this cycle |
| in_data | input | 1024 | 128 bytes, byte j at bits 8j+7:8j |
| out_valid | output | 1 | Output planes and classes valid |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_planes | output | 1024 | Eight bit planes of 128 positions, plane i at 128i+127:128i |
| out_class | output | 512 | Four class streams of 128 positions, class k at 128k+127:128k |

## Verification
Planes and class streams for an accepted block are due one register stage later. They are on the outputs right after the accepting edge and stay there until the edge on which `out_ready` is high. The driver drives on the falling edge and checks `out_valid` just after the accepting rising edge. The monitor compares against the queued expected block only at falling-edge sample points where `out_valid` and `out_ready` are both high. At every stalled sample point it also confirms that the held values are unchanged one cycle later, and it checks the asynchronous reset a fraction of a cycle after `rst_n` falls.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int BYTE_BITS   = 8;
  localparam int CODES       = 1 << BYTE_BITS;
  localparam int DEF_CLASSES = 4;

  typedef logic [DEF_CLASSES-1:0][CODES-1:0] class_map_t;

  // Default classes: digit range, {z,9}, negated digits, any-but-newline.
  function automatic class_map_t build_default_maps();
    class_map_t m;
    logic       is_digit;
    for (int v = 0; v < CODES; v++) begin
      is_digit = (v >= 'h30) && (v <= 'h39);
      m[0][v]  = is_digit;
      m[1][v]  = (v == 'h7A) || (v == 'h39);
      m[2][v]  = !is_digit;
      m[3][v]  = (v != 'h0A);
    end
    return m;
  endfunction
endpackage

// File: rtl/cc_transpose.sv
module cc_transpose #(
  parameter int N = 128
) (
  input  logic [N*cc_pkg::BYTE_BITS-1:0]          bytes_in,
  output logic [cc_pkg::BYTE_BITS-1:0][N-1:0]     planes
);
  localparam int BB = cc_pkg::BYTE_BITS;

  // Plane i, position j <- bit i of byte j.
  for (genvar i = 0; i < BB; i++) begin : g_plane
    for (genvar j = 0; j < N; j++) begin : g_pos
      assign planes[i][j] = bytes_in[BB*j + i];
    end
  end
endmodule

// File: rtl/cc_class_tree.sv
module cc_class_tree #(
  parameter int                       W   = 128,
  parameter logic [cc_pkg::CODES-1:0] MAP = '0
) (
  input  logic [cc_pkg::BYTE_BITS-1:0][W-1:0] planes,
  output logic [W-1:0]                        hit
);
  localparam int LEVELS = cc_pkg::BYTE_BITS;
  localparam int LEAVES = 1 << LEVELS;

  // Heap-ordered tree: node n has children 2n (bit 0) and 2n+1 (bit 1).
  logic [W-1:0] node [1:2*LEAVES-1];

  for (genvar v = 0; v < LEAVES; v++) begin : g_leaf
    assign node[LEAVES + v] = {W{MAP[v]}};
  end

  // Depth d selects on plane (LEVELS-1-d), the most significant bit first.
  for (genvar d = 0; d < LEVELS; d++) begin : g_lvl
    for (genvar k = 0; k < (1 << d); k++) begin : g_node
      localparam int NID = (1 << d) + k;
      assign node[NID] = (planes[LEVELS-1-d]  & node[2*NID+1])
                       | (~planes[LEVELS-1-d] & node[2*NID]);
    end
  end

  assign hit = node[1];
endmodule

// File: rtl/cc_out_reg.sv
module cc_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic vld_q, vld_nxt, load;

  always_comb begin
    up_ready = !vld_q || dn_ready;
    load     = up_valid && up_ready;
    if (load)          vld_nxt = 1'b1;
    else if (dn_ready) vld_nxt = 1'b0;
    else               vld_nxt = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_nxt;
  end

  always_ff @(posedge clk) begin
    if (load) dn_data <= up_data;
  end

  assign dn_valid = vld_q;

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> dn_valid) else $error("accept"); // R7

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data))) else $error("hold"); // R8

  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_ready && !up_valid) |=> !dn_valid) else $error("drain"); // R10
endmodule

// File: rtl/bitplane_classifier.sv
module bitplane_classifier #(
  parameter int N           = 128,
  parameter int NUM_CLASSES = 4,
  parameter logic [NUM_CLASSES-1:0][cc_pkg::CODES-1:0] CLASS_MAP =
    cc_pkg::build_default_maps()
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_valid,
  output logic                                  in_ready,
  input  logic [N*cc_pkg::BYTE_BITS-1:0]        in_data,
  output logic                                  out_valid,
  input  logic                                  out_ready,
  output logic [N*cc_pkg::BYTE_BITS-1:0]        out_planes,
  output logic [N*NUM_CLASSES-1:0]              out_class
);
  localparam int BB     = cc_pkg::BYTE_BITS;
  localparam int PLANE_W = N * BB;
  localparam int CLASS_W = N * NUM_CLASSES;
  localparam int REG_W   = PLANE_W + CLASS_W;

  logic [BB-1:0][N-1:0]          planes;
  logic [NUM_CLASSES-1:0][N-1:0] classes;
  logic [REG_W-1:0]              reg_d, reg_q;

  cc_transpose #(.N(N)) u_transpose (
    .bytes_in (in_data),
    .planes   (planes)
  );

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
    cc_class_tree #(.W(N), .MAP(CLASS_MAP[c])) u_tree (
      .planes (planes),
      .hit    (classes[c])
    );
  end

  assign reg_d = {classes, planes};

  cc_out_reg #(.W(REG_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (reg_d),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (reg_q)
  );

  assign out_planes = reg_q[PLANE_W-1:0];
  assign out_class  = reg_q[REG_W-1:PLANE_W];

  // Byte 0 rebuilt from the registered planes must equal the accepted byte.
  logic [BB-1:0] byte0_back;
  for (genvar i = 0; i < BB; i++) begin : g_back
    assign byte0_back[i] = out_planes[N*i];
  end

  AST_BYTE0_ROUNDTRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (byte0_back == $past(in_data[BB-1:0])))
    else $error("byte0"); // R1
endmodule

// File: tb/test_bitplane_classifier.sv
`timescale 1ns/1ps
module test_bitplane_classifier;
  localparam int N  = 128;
  localparam int C  = 4;
  localparam int DW = N * 8;
  localparam int CW = N * C;

  typedef struct packed {
    logic [DW-1:0] planes;
    logic [CW-1:0] cls;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [DW-1:0] in_data;
  logic          out_valid;
  logic          out_ready;
  logic [DW-1:0] out_planes;
  logic [CW-1:0] out_class;

  int checks = 0;
  int fails  = 0;
  int ready_mode = 1;
  int cyc = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  bitplane_classifier i_bitplane_classifier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_planes(out_planes), .out_class(out_class)
  );

  function automatic bit member(int k, logic [7:0] b);
    case (k)
      0: return (b >= 8'h30) && (b <= 8'h39);
      1: return (b == 8'h7A) || (b == 8'h39);
      2: return !((b >= 8'h30) && (b <= 8'h39));
      default: return b != 8'h0A;
    endcase
  endfunction

  function automatic exp_t model(logic [DW-1:0] blk);
    exp_t e;
    for (int j = 0; j < N; j++) begin
      for (int i = 0; i < 8; i++) e.planes[N*i + j] = blk[8*j + i];
      for (int k = 0; k < C; k++) e.cls[N*k + j] = member(k, blk[8*j +: 8]);
    end
    return e;
  endfunction

  task automatic check(bit ok, string req, logic [1023:0] act, logic [1023:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    case (ready_mode)
      0: out_ready <= 1'b0;
      1: out_ready <= 1'b1;
      2: out_ready <= cyc[0];
      default: out_ready <= (cyc[1:0] == 2'b00);
    endcase
  end

  // Monitor: samples between edges.
  bit            stalled = 1'b0;
  logic [DW-1:0] snap_p;
  logic [CW-1:0] snap_c;
  string         ctag [C] = '{"R3", "R4", "R5", "R6"};
  always @(negedge clk) begin
    #2;
    if (!rst_n) stalled = 1'b0;
    else begin
      if (stalled) begin
        check(out_valid == 1'b1, "R8 valid held", 1024'(out_valid), 1);
        check(out_planes == snap_p && out_class == snap_c, "R8 data held",
              1024'(out_class), 1024'(snap_c));
      end
      stalled = 1'b0;
      if (out_valid && !out_ready) begin
        stalled = 1'b1;
        snap_p  = out_planes;
        snap_c  = out_class;
        check(in_ready == 1'b0, "R8 in_ready low", 1024'(in_ready), 0);
      end
      if (out_valid && out_ready) begin
        if (q.size() == 0) check(1'b0, "R7 unexpected output", 1024'(1), 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(out_planes == e.planes, "R1 planes", out_planes, e.planes);
          for (int k = 0; k < C; k++)
            check(out_class[N*k +: N] == e.cls[N*k +: N],
                  $sformatf("R2 %s class %0d", ctag[k], k),
                  1024'(out_class[N*k +: N]), 1024'(e.cls[N*k +: N]));
        end
      end
    end
  end

  task automatic send(logic [DW-1:0] blk, bit immediate);
    int waits = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = blk;
    #1;
    while (!in_ready) begin
      waits++;
      @(negedge clk);
      #1;
    end
    if (immediate) check(waits == 0, "R10 back-to-back accept", 1024'(waits), 0);
    q.push_back(model(blk));
    @(posedge clk);
    #1;
    check(out_valid == 1'b1, "R7 valid after accept", 1024'(out_valid), 1);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((q.size() != 0 || out_valid) && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  function automatic logic [DW-1:0] fill(logic [7:0] b);
    logic [DW-1:0] r;
    for (int j = 0; j < N; j++) r[8*j +: 8] = b;
    return r;
  endfunction

  function automatic logic [DW-1:0] ramp(int base);
    logic [DW-1:0] r;
    for (int j = 0; j < N; j++) r[8*j +: 8] = 8'(base + j);
    return r;
  endfunction

  function automatic logic [DW-1:0] text_block();
    string s = "x71z-9q\nz--a0-9az99\n.^[]07";
    logic [DW-1:0] r;
    for (int j = 0; j < N; j++) r[8*j +: 8] = s[j % s.len()];
    return r;
  endfunction

  function automatic logic [DW-1:0] noise(int seed);
    logic [DW-1:0] r;
    logic [31:0] x = 32'h1234_5678 ^ 32'(seed * 7919);
    for (int j = 0; j < N; j++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      r[8*j +: 8] = x[7:0];
    end
    return r;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R9 reset out_valid", 1024'(out_valid), 0);
    check(in_ready == 1'b1, "R9 reset in_ready", 1024'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    ready_mode = 1;
    send(text_block(), 1'b0);
    send(ramp(0), 1'b1);
    send(ramp(128), 1'b1);
    send(fill(8'h0A), 1'b1);
    send(fill(8'hFF), 1'b1);
    send(fill(8'h00), 1'b1);
    idle();
    drain();

    ready_mode = 2;
    for (int s = 0; s < 6; s++) send(noise(s), 1'b0);
    idle();
    drain();

    ready_mode = 3;
    for (int s = 6; s < 10; s++) send(noise(s), 1'b0);
    idle();
    drain();

    // Reset while a block is stalled at the output.
    ready_mode = 0;
    send(ramp(40), 1'b0);
    idle();
    repeat (2) @(negedge clk);
    #3;
    rst_n = 1'b0;
    #1;
    check(out_valid == 1'b0, "R9 async clear", 1024'(out_valid), 0);
    q.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ready_mode = 1;
    send(ramp(48), 1'b0);
    idle();
    drain();

    done = 1'b1;
    summary();
  end
endmodule